// File: doc/BRIEF.md
# Dual-Synthesizer Serial Configuration Port

This block is the write-only control port of a dual frequency synthesizer with an IF loop and an RF loop. A host drives three lines: a serial clock, a serial data line and a load strobe. The lines are brought into the system clock domain, and each serial-clock rising edge shifts one data bit into a 24-bit word, most significant bit first. A rising edge of the load strobe copies the word into one of four configuration latches. The latch is chosen by the two lowest bits of the word.

The latched fields go straight to the dividers and charge pumps of both loops:

- reference divide value
- swallow and main counter values
- prescaler select
- detector polarity
- charge-pump three-state and current code
- power-down
- fast-lock enable

Each side reports when both of its latches have been written. Until all four latches have been written once, both loops are held in power-down with their charge pumps three-stated.

Power-down follows an ordered sequence. If the loaded word leaves the charge pump active, the pump is three-stated first and power-down follows one cycle later. If the word already three-states the pump, power-down takes effect in the cycle the latch updates. Fast-lock is carried in the counter word, so one write both retunes the loop and forces the pump current to its maximum code.

Top module: `synth_cfg_port`

## Requirements
- R1: On each rising edge of `ser_clk` while `ser_load` is low, `ser_dat` shifts into bit 0 of a 24-bit word and the older bits move one place toward bit 23, so the last 24 bits form the word, first bit sent in bit 23.
- R2: A rising edge of `ser_load` copies the word into the latch addressed by bits [1:0]: 00 IF reference, 01 IF counter, 10 RF reference, 11 RF counter. The other three latches keep their contents.
- R3: Reference word fields are: [15:2] divide value, [16] polarity, [17] pump three-state, [20:18] current code, [21] power-down. A divide value of 0 is presented as 1 on `r_div`.
- R4: Counter word fields are: [7:2] swallow value `a_cnt`, [19:8] main value `b_cnt`, [21:20] prescaler select, [22] fast-lock enable.
- R5: Serial clock edges while `ser_load` is high are ignored. A load after fewer than 24 new bits transfers whatever the word holds at that moment.
- R6: `side_prog[s]` is high once both latches of side s (0 = IF, 1 = RF) have been written. Until `all_prog` is high, both sides show `pwr_dn`=1, `cp_hiz`=1 and `fast_lock`=0. `all_prog` never falls once set.
- R7: When a load sets power-down while the three-state bit of that word is 0, `cp_hiz` rises in the cycle the latch updates (third system clock after the load strobe is applied) and `pwr_dn` rises one cycle later.
- R8: When the loaded word has both power-down and three-state set, `pwr_dn` and `cp_hiz` rise together in the cycle the latch updates.
- R9: Loads are accepted during power-down. A load that clears power-down (with three-state 0) drops `pwr_dn` and `cp_hiz` in the cycle the latch updates.
- R10: While fast-lock is enabled on a programmed side, `fast_lock` is 1 and `cp_cur` shows the maximum code 7. Clearing the bit restores the programmed code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe, rising edge transfers the word |
| r_div | output | 2x14 | Reference divide value per side (index 0 IF, 1 RF) |
| a_cnt | output | 2x6 | Swallow counter value per side |
| b_cnt | output | 2x12 | Main counter value per side |
| psel | output | 2x2 | Prescaler select per side |
| pol | output | 2 | Detector polarity per side |
| cp_hiz | output | 2 | Charge pump three-state per side |
| cp_cur | output | 2x3 | Charge pump current code per side |
| pwr_dn | output | 2 | Power-down per side |
| fast_lock | output | 2 | Fast-lock active per side |
| side_prog | output | 2 | Both latches of the side written |
| all_prog | output | 1 | All four latches written |

## Verification
The hardest case to reach is the one-cycle gap between pump three-state and power-down. At the ports it shows only as a difference of one system clock in the arrival of `pwr_dn`. The bench applies the load strobe right after a falling clock edge and counts falling edges until each output changes. It expects the latch-update cycle for `cp_hiz` and one cycle more for `pwr_dn` in the ordered case, and the same cycle for both when the word carries three-state. Ignored shifts are brought about by pulsing the serial clock with ones while the strobe is high and then sending a short 8-bit tail, so the resulting word reveals whether any of those bits entered the register.

// File: rtl/synth_cfg_pkg.sv
// Shared widths and word layouts of the synthesizer configuration port.
// Assumes a 24-bit word whose two lowest bits select the target latch.
package synth_cfg_pkg;
    localparam int unsigned WORD_W  = 24;
    localparam int unsigned ADDR_W  = 2;
    localparam int unsigned N_LATCH = 1 << ADDR_W;
    localparam int unsigned N_SIDE  = N_LATCH / 2;
    localparam int unsigned R_W     = 14;
    localparam int unsigned A_W     = 6;
    localparam int unsigned B_W     = 12;
    localparam int unsigned CUR_W   = 3;
    localparam int unsigned PS_W    = 2;

    // Reference latch word, MSB first.
    typedef struct packed {
        logic [1:0]        spare;
        logic              pd;
        logic [CUR_W-1:0]  cur;
        logic              hz;
        logic              pol;
        logic [R_W-1:0]    r;
        logic [ADDR_W-1:0] addr;
    } ref_word_t;

    // Counter latch word, MSB first.
    typedef struct packed {
        logic              spare;
        logic              fl;
        logic [PS_W-1:0]   psel;
        logic [B_W-1:0]    b;
        logic [A_W-1:0]    a;
        logic [ADDR_W-1:0] addr;
    } ab_word_t;
endpackage

// File: rtl/sig_sync.sv
// Brings one asynchronous line into the clk domain and flags its rising edge.
// Assumes the line holds each level for more than STAGES+1 clk cycles.
module sig_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the line through the synchronizer chain and keep the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/word_shifter.sv
// Serial-in shift register; a new bit enters at bit 0, MSB arrives first.
// Assumes shift_en is a single-cycle pulse per serial clock edge.
module word_shifter #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    // Move the word one place up and take the new bit at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[W-2:0], bit_in};
    end
endmodule

// File: rtl/cfg_latch_bank.sv
// Bank of N configuration latches addressed by the low bits of the word.
// Assumes load is a single-cycle pulse; tracks which latches were written.
module cfg_latch_bank #(
    parameter int unsigned W  = 24,
    parameter int unsigned AW = 2,
    localparam int unsigned N = 1 << AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [W-1:0]        word,
    output logic [N-1:0][W-1:0] lat,
    output logic [N-1:0]        written
);
    for (genvar i = 0; i < N; i++) begin : g_lat
        // Capture the word when it addresses this latch.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat[i]     <= '0;
                written[i] <= 1'b0;
            end else if (load && (word[AW-1:0] == AW'(i))) begin
                lat[i]     <= word;
                written[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/side_ctrl.sv
// Field decode and power/fast-lock sequencing for one loop (IF or RF).
// Assumes active is high only after all latches have been written once.
module side_ctrl
    import synth_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [WORD_W-1:0] ref_w,
    input  logic [WORD_W-1:0] ab_w,
    output logic [R_W-1:0]    r_div,
    output logic [A_W-1:0]    a_cnt,
    output logic [B_W-1:0]    b_cnt,
    output logic [PS_W-1:0]   psel,
    output logic              pol,
    output logic              cp_hiz,
    output logic [CUR_W-1:0]  cp_cur,
    output logic              pwr_dn,
    output logic              fast_lock
);
    ref_word_t rw;
    ab_word_t  aw;
    logic      pd_arm;
    logic      unused_spare;

    assign rw = ref_word_t'(ref_w);
    assign aw = ab_word_t'(ab_w);
    assign unused_spare = ^{rw.spare, rw.addr, aw.spare, aw.addr};

    // Delay the power-down request by one cycle for the ordered sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) pd_arm <= 1'b0;
        else        pd_arm <= rw.pd;
    end

    // Decode fields, clamp a zero divide value and apply the gating.
    always_comb begin
        r_div     = (rw.r == '0) ? R_W'(1) : rw.r;
        a_cnt     = aw.a;
        b_cnt     = aw.b;
        psel      = aw.psel;
        pol       = rw.pol;
        cp_hiz    = ~active | rw.hz | rw.pd;
        pwr_dn    = ~active | (rw.pd & (rw.hz | pd_arm));
        fast_lock = active & aw.fl;
        cp_cur    = aw.fl ? {CUR_W{1'b1}} : rw.cur;
    end
endmodule

// File: rtl/synth_cfg_port.sv
// Top of the three-line configuration port for a dual synthesizer.
// Assumes the serial lines are slow against clk (several cycles per level).
module synth_cfg_port
    import synth_cfg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ser_clk,
    input  logic                         ser_dat,
    input  logic                         ser_load,
    output logic [N_SIDE-1:0][R_W-1:0]   r_div,
    output logic [N_SIDE-1:0][A_W-1:0]   a_cnt,
    output logic [N_SIDE-1:0][B_W-1:0]   b_cnt,
    output logic [N_SIDE-1:0][PS_W-1:0]  psel,
    output logic [N_SIDE-1:0]            pol,
    output logic [N_SIDE-1:0]            cp_hiz,
    output logic [N_SIDE-1:0][CUR_W-1:0] cp_cur,
    output logic [N_SIDE-1:0]            pwr_dn,
    output logic [N_SIDE-1:0]            fast_lock,
    output logic [N_SIDE-1:0]            side_prog,
    output logic                         all_prog
);
    logic [2:0] lvl, rise;
    logic [2:0] raw;
    logic [WORD_W-1:0] word;
    logic [N_LATCH-1:0][WORD_W-1:0] lat;
    logic [N_LATCH-1:0] written;
    logic unused_edges;

    assign raw = {ser_load, ser_dat, ser_clk};
    assign unused_edges = ^{rise[1], lvl[0]};

    for (genvar i = 0; i < 3; i++) begin : g_sync
        sig_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk (clk), .rst_n (rst_n), .din (raw[i]),
            .lvl (lvl[i]), .rise (rise[i])
        );
    end

    word_shifter #(.W(WORD_W)) i_shift (
        .clk (clk), .rst_n (rst_n),
        .shift_en (rise[0] & ~lvl[2]),
        .bit_in (lvl[1]),
        .word (word)
    );

    cfg_latch_bank #(.W(WORD_W), .AW(ADDR_W)) i_bank (
        .clk (clk), .rst_n (rst_n), .load (rise[2]),
        .word (word), .lat (lat), .written (written)
    );

    assign all_prog = &written;

    for (genvar s = 0; s < N_SIDE; s++) begin : g_side
        assign side_prog[s] = written[2*s] & written[2*s+1];
        side_ctrl i_side (
            .clk (clk), .rst_n (rst_n), .active (all_prog),
            .ref_w (lat[2*s]), .ab_w (lat[2*s+1]),
            .r_div (r_div[s]), .a_cnt (a_cnt[s]), .b_cnt (b_cnt[s]),
            .psel (psel[s]), .pol (pol[s]), .cp_hiz (cp_hiz[s]),
            .cp_cur (cp_cur[s]), .pwr_dn (pwr_dn[s]),
            .fast_lock (fast_lock[s])
        );
    end
endmodule

// File: rtl/synth_cfg_port_chk.sv
// Property checker for synth_cfg_port, attached by bind below.
module synth_cfg_port_chk
    import synth_cfg_pkg::*;
(
    input logic                         clk,
    input logic                         rst_n,
    input logic [N_SIDE-1:0][R_W-1:0]   r_div,
    input logic [N_SIDE-1:0]            cp_hiz,
    input logic [N_SIDE-1:0][CUR_W-1:0] cp_cur,
    input logic [N_SIDE-1:0]            pwr_dn,
    input logic [N_SIDE-1:0]            fast_lock,
    input logic [N_SIDE-1:0]            side_prog,
    input logic                         all_prog
);
    // R6: outputs held inactive until fully programmed.
    a_r6_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !all_prog |-> (pwr_dn == '1) && (cp_hiz == '1) && (fast_lock == '0));
    // R6: programming status never drops.
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        all_prog |=> all_prog);
    // R6: full programming implies each side programmed.
    a_r6_sides: assert property (@(posedge clk) disable iff (!rst_n)
        all_prog |-> side_prog == '1);

    for (genvar s = 0; s < N_SIDE; s++) begin : g_s
        // R7: a powered-down side always has its pump three-stated.
        a_r7_pd_hiz: assert property (@(posedge clk) disable iff (!rst_n)
            pwr_dn[s] |-> cp_hiz[s]);
        // R10: fast-lock drives maximum current.
        a_r10_max_cur: assert property (@(posedge clk) disable iff (!rst_n)
            fast_lock[s] |-> cp_cur[s] == '1);
        // R3: divide value never presented as zero.
        a_r3_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
            r_div[s] != '0);
    end
endmodule

bind synth_cfg_port synth_cfg_port_chk i_chk (
    .clk (clk), .rst_n (rst_n), .r_div (r_div), .cp_hiz (cp_hiz),
    .cp_cur (cp_cur), .pwr_dn (pwr_dn), .fast_lock (fast_lock),
    .side_prog (side_prog), .all_prog (all_prog)
);

// File: tb/test_synth_cfg_port.sv
module test_synth_cfg_port;
    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
    logic [1:0][13:0] r_div;
    logic [1:0][5:0]  a_cnt;
    logic [1:0][11:0] b_cnt;
    logic [1:0][1:0]  psel;
    logic [1:0]       pol, cp_hiz, pwr_dn, fast_lock, side_prog;
    logic [1:0][2:0]  cp_cur;
    logic             all_prog;
    int checks = 0, errors = 0;
    logic done = 1'b0;

    logic [23:0] sh = '0;
    logic [3:0][23:0] mlat = '0;
    logic [3:0] mwr = '0;

    always #2.5 clk = ~clk;

    synth_cfg_port i_synth_cfg_port (
        .clk (clk), .rst_n (rst_n), .ser_clk (sclk), .ser_dat (sdat),
        .ser_load (sle), .r_div (r_div), .a_cnt (a_cnt), .b_cnt (b_cnt),
        .psel (psel), .pol (pol), .cp_hiz (cp_hiz), .cp_cur (cp_cur),
        .pwr_dn (pwr_dn), .fast_lock (fast_lock), .side_prog (side_prog),
        .all_prog (all_prog)
    );

    function automatic logic [23:0] mk_ref(input logic side, input logic [13:0] r,
        input logic p, input logic hz, input logic [2:0] cur, input logic pd);
        return {2'b00, pd, cur, hz, p, r, side, 1'b0};
    endfunction

    function automatic logic [23:0] mk_ab(input logic side, input logic [5:0] a,
        input logic [11:0] b, input logic [1:0] ps, input logic fl);
        return {1'b0, fl, ps, b, a, side, 1'b1};
    endfunction

    localparam logic [23:0] VEC [10] = '{
        mk_ref(1'b0, 14'd100,   1'b1, 1'b0, 3'd3, 1'b0),
        mk_ab (1'b0, 6'd5,   12'd200,  2'd1, 1'b0),
        mk_ref(1'b1, 14'd0,     1'b0, 1'b0, 3'd5, 1'b0),
        mk_ab (1'b1, 6'd63,  12'd4095, 2'd3, 1'b0),
        mk_ab (1'b0, 6'd0,   12'd3,    2'd2, 1'b1),
        mk_ref(1'b0, 14'd16383, 1'b0, 1'b0, 3'd1, 1'b0),
        mk_ab (1'b0, 6'd7,   12'd9,    2'd0, 1'b0),
        mk_ref(1'b1, 14'd1,     1'b1, 1'b0, 3'd2, 1'b0),
        mk_ab (1'b1, 6'd21,  12'd2730, 2'd1, 1'b1),
        mk_ab (1'b1, 6'd42,  12'd1365, 2'd2, 1'b0)
    };

    function automatic logic [84:0] act_vec();
        return {r_div, a_cnt, b_cnt, psel, pol, cp_hiz, cp_cur, pwr_dn,
                fast_lock, side_prog, all_prog};
    endfunction

    // Expected steady-state outputs from the requirement field positions.
    function automatic logic [84:0] exp_vec();
        logic [1:0][13:0] er; logic [1:0][5:0] ea; logic [1:0][11:0] eb;
        logic [1:0][1:0] ep; logic [1:0] epol, ehz, epd, efl, esp;
        logic [1:0][2:0] ec; logic all;
        all = &mwr;
        for (int s = 0; s < 2; s++) begin
            er[s]   = (mlat[2*s][15:2] == 0) ? 14'd1 : mlat[2*s][15:2];
            epol[s] = mlat[2*s][16];
            epd[s]  = !all | mlat[2*s][21];
            ehz[s]  = !all | mlat[2*s][17] | mlat[2*s][21];
            ea[s]   = mlat[2*s+1][7:2];
            eb[s]   = mlat[2*s+1][19:8];
            ep[s]   = mlat[2*s+1][21:20];
            efl[s]  = all & mlat[2*s+1][22];
            ec[s]   = mlat[2*s+1][22] ? 3'd7 : mlat[2*s][20:18];
            esp[s]  = mwr[2*s] & mwr[2*s+1];
        end
        return {er, ea, eb, ep, epol, ehz, ec, epd, efl, esp, all};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [84:0] act,
                       input logic [84:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [23:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdat = w[i]; tick(2); sclk = 1'b1; tick(2); sclk = 1'b0;
            sh = {sh[22:0], w[i]};
        end
    endtask

    task automatic model_load();
        mlat[sh[1:0]] = sh;
        mwr[sh[1:0]]  = 1'b1;
    endtask

    task automatic pulse_load();
        sle = 1'b1; model_load(); tick(3); sle = 1'b0; tick(8);
    endtask

    task automatic cmp_all(input string req);
        chk(act_vec() === exp_vec(), req, act_vec(), exp_vec());
    endtask

    // Apply the strobe and count clk cycles until pwr_dn / cp_hiz change.
    task automatic load_timed(input int s, output int k_pd, output int k_hz);
        logic pd0, hz0;
        pd0 = pwr_dn[s]; hz0 = cp_hiz[s]; k_pd = -1; k_hz = -1;
        sle = 1'b1; model_load();
        for (int k = 1; k <= 12; k++) begin
            tick(1);
            if (k_pd < 0 && pwr_dn[s] != pd0) k_pd = k;
            if (k_hz < 0 && cp_hiz[s] != hz0) k_hz = k;
        end
        sle = 1'b0; tick(8);
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int kp, kh;
        tick(4); rst_n = 1'b1; tick(2);
        // R6 R3: reset state, nothing programmed, zero divide shown as 1.
        cmp_all("R6/R3 reset state");

        // R1 R2 R3 R4 R6 R10: table walk, full output compare after each load.
        for (int i = 0; i < 10; i++) begin
            shift_bits(VEC[i], 24); pulse_load();
            cmp_all($sformatf("R1/R2/R3/R4/R6/R10 vector %0d", i));
        end

        // R5: extra serial clocks while the strobe is high are ignored.
        shift_bits(mk_ab(1'b0, 6'd33, 12'd1234, 2'd3, 1'b0), 24);
        sle = 1'b1; model_load(); tick(3);
        for (int j = 0; j < 5; j++) begin
            sdat = 1'b1; tick(2); sclk = 1'b1; tick(2); sclk = 1'b0;
        end
        sle = 1'b0; tick(8);
        cmp_all("R5 shifts during strobe");
        // R5: short 8-bit load transfers the shifted word.
        shift_bits(24'h000015, 8); pulse_load();
        cmp_all("R5 short load");

        // R7: ordered power-down, pump three-state one cycle before power-down.
        shift_bits(mk_ref(1'b0, 14'd50, 1'b0, 1'b0, 3'd2, 1'b1), 24);
        load_timed(0, kp, kh);
        chk(kh == 3, "R7 cp_hiz latency", 85'(kh), 85'(3));
        chk(kp == 4, "R7 pwr_dn latency", 85'(kp), 85'(4));

        // R9: loads are accepted while powered down.
        shift_bits(mk_ab(1'b0, 6'd9, 12'd77, 2'd1, 1'b0), 24); pulse_load();
        cmp_all("R9 load during power-down");
        // R9: clearing power-down releases both outputs at the latch update.
        shift_bits(mk_ref(1'b0, 14'd50, 1'b0, 1'b0, 3'd2, 1'b0), 24);
        load_timed(0, kp, kh);
        chk(kp == 3, "R9 pwr_dn release", 85'(kp), 85'(3));
        chk(kh == 3, "R9 cp_hiz release", 85'(kh), 85'(3));

        // R8: word with three-state and power-down acts at the latch update.
        shift_bits(mk_ref(1'b1, 14'd30, 1'b0, 1'b1, 3'd4, 1'b1), 24);
        load_timed(1, kp, kh);
        chk(kp == 3, "R8 pwr_dn immediate", 85'(kp), 85'(3));
        chk(kh == 3, "R8 cp_hiz immediate", 85'(kh), 85'(3));
        cmp_all("R8/R2 final state");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule